// File: doc/BRIEF.md
# Strap-Latched Frequency Select Control

This block sits between three dual-purpose pads and the clock synthesizer's frequency control. While power-on reset is held, the pads are inputs carrying board straps for the low three frequency-select bits. When reset is released, the block samples those strap levels through a synchronizer, freezes them, and then, after a short hand-off interval, turns on the pad output drivers so the pads can carry reference clocks. The frozen strap value stays put until the next power-on reset.

After hand-off, the block forms the working 5-bit frequency code. A source-select field chooses between the frozen straps (low three bits) and the register-programmed select bits. The block also decodes two spread-spectrum enables and a high-impedance request for the all-zero code. The frozen strap value is exported so that the register file can use it as the power-up value of its low three select bits.

The sequencer is a three-state machine. SAMPLE: the pads are inputs and outputs are parked. LATCH: the straps have been frozen and the drivers are still off, for HANDOFF_CYC clocks. RUN: the drivers are on and the code is live. Transitions: SAMPLE→LATCH when the synchronized power-on reset deasserts (capture on that edge). LATCH→RUN when the hand-off count expires. Any state→SAMPLE when the synchronized power-on reset asserts.

Top module: `fsel_strap_ctrl`

## Requirements
- R1: While the synchronized power-on reset is asserted (por_n low), pin_oe is all 0, fs_code is 0, hiz_req is 1, and cpu_ss_on and src_ss_on are 0.
- R2: On the clock edge where the synchronized por_n is first seen high, strap_in (passed through SYNC_STAGES flops) is frozen. It appears on fs_default, with bit i taken from strap_in[i].
- R3: pin_oe becomes all 1 exactly HANDOFF_CYC clocks after the capture edge and stays 0 until then.
- R4: After capture, changes on strap_in have no effect on fs_default or fs_code until the next power-on reset.
- R5: In RUN with src_sel = 0, fs_code = {reg_fs[4:3], fs_default}. With src_sel = 1, fs_code = reg_fs.
- R6: In RUN, hiz_req is 1 exactly when fs_code is 5'b00000.
- R7: In RUN, cpu_ss_on = ss_en AND fs_code[4] (bit 4 set selects the down-spread code group).
- R8: src_ss_on is 1 only when cpu_ss_on is 1 and src_ss_en is 1; this is full spread, needing three bits set.
- R9: Reasserting por_n during RUN returns the block to SAMPLE with pin_oe all 0. The next release captures the new strap levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| por_n | input | 1 | Power-on reset from pad, active low, asynchronous to clk |
| strap_in | input | 3 | Pad input levels of the dual-purpose strap pins |
| src_sel | input | 1 | 0: low select bits from frozen straps, 1: all bits from register |
| ss_en | input | 1 | Register spread enable |
| reg_fs | input | 5 | Register-programmed frequency-select bits |
| src_ss_en | input | 1 | Register spread enable for the serial-reference clocks |
| pin_oe | output | 3 | Output-driver enable per strap pin |
| fs_default | output | 3 | Frozen strap value, used as register power-up value |
| fs_code | output | 5 | Effective frequency-select code |
| hiz_req | output | 1 | Request to float the processor, link and bus clocks |
| cpu_ss_on | output | 1 | Spread active on the main PLL |
| src_ss_on | output | 1 | Spread active on the serial-reference clocks |

## Verification
The bench builds the block with SYNC_STAGES = 3 and HANDOFF_CYC = 2. A deeper synchronizer and a hand-off counter that must count past one show whether capture and driver turn-on land on the exact edges that R2 and R3 predict. They also show that the counter is not bypassed. Random register fields and strap patterns are applied across two power-on cycles, so recapture after R9 is observed with different straps. The all-zero code and the spread combinations are also forced directly.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
    localparam int FS_W    = 5;
    localparam int STRAP_W = 3;

    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,
        ST_LATCH  = 2'd1,
        ST_RUN    = 2'd2
    } seq_state_t;
endpackage

// File: rtl/fsel_sync.sv
module fsel_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= d;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/fsel_seq.sv
module fsel_seq
    import fsel_pkg::*;
#(
    parameter int HANDOFF_CYC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_ok,
    input  logic [STRAP_W-1:0] strap_sync,
    output logic               run,
    output logic [STRAP_W-1:0] pin_oe,
    output logic [STRAP_W-1:0] strap_lat
);
    localparam int CNT_W = (HANDOFF_CYC > 1) ? $clog2(HANDOFF_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HANDOFF_CYC - 1);

    seq_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAMPLE: if (por_ok) state_d = ST_LATCH;
            ST_LATCH:  if (!por_ok) state_d = ST_SAMPLE;
                       else if (cnt_q == CNT_LAST) state_d = ST_RUN;
            ST_RUN:    if (!por_ok) state_d = ST_SAMPLE;
            default:   state_d = ST_SAMPLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_SAMPLE;
            cnt_q     <= '0;
            strap_lat <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SAMPLE && state_d == ST_LATCH) begin
                strap_lat <= strap_sync;
            end
            if (state_q == ST_LATCH && state_d == ST_LATCH) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    always_comb begin
        run    = (state_q == ST_RUN);
        pin_oe = run ? '1 : '0;
    end

    AST_POR_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        !por_ok |=> (state_q == ST_SAMPLE)) else $error("por park");     // R1
    AST_FROZEN_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SAMPLE) && por_ok |=> $stable(strap_lat)) else $error("hold"); // R4
    AST_LATCH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH) |-> (cnt_q <= CNT_LAST)) else $error("cnt"); // R3
endmodule

// File: rtl/fsel_decode.sv
module fsel_decode
    import fsel_pkg::*;
(
    input  logic               run,
    input  logic [STRAP_W-1:0] strap_lat,
    input  logic               src_sel,
    input  logic               ss_en,
    input  logic [FS_W-1:0]    reg_fs,
    input  logic               src_ss_en,
    output logic [FS_W-1:0]    fs_code,
    output logic               hiz_req,
    output logic               cpu_ss_on,
    output logic               src_ss_on
);
    logic [FS_W-1:0] sel_code;

    always_comb begin
        sel_code  = src_sel ? reg_fs : {reg_fs[FS_W-1:STRAP_W], strap_lat};
        fs_code   = run ? sel_code : '0;
        hiz_req   = !run || (sel_code == '0);
        cpu_ss_on = run && ss_en && sel_code[FS_W-1];
        src_ss_on = cpu_ss_on && src_ss_en;
    end

    always_comb begin
        AST_HIZ_ZERO: assert (!(run && fs_code == '0) || hiz_req) else $error("hiz"); // R6
        AST_SRC_NEEDS_CPU: assert (!src_ss_on || cpu_ss_on) else $error("ss");     // R8
    end
endmodule

// File: rtl/fsel_strap_ctrl.sv
module fsel_strap_ctrl
    import fsel_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HANDOFF_CYC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_n,
    input  logic [STRAP_W-1:0] strap_in,
    input  logic               src_sel,
    input  logic               ss_en,
    input  logic [FS_W-1:0]    reg_fs,
    input  logic               src_ss_en,
    output logic [STRAP_W-1:0] pin_oe,
    output logic [STRAP_W-1:0] fs_default,
    output logic [FS_W-1:0]    fs_code,
    output logic               hiz_req,
    output logic               cpu_ss_on,
    output logic               src_ss_on
);
    logic               por_ok;
    logic [STRAP_W-1:0] strap_sync;
    logic               run;

    fsel_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_por_sync (
        .clk(clk), .rst_n(rst_n), .d(por_n), .q(por_ok));

    fsel_sync #(.WIDTH(STRAP_W), .STAGES(SYNC_STAGES)) u_strap_sync (
        .clk(clk), .rst_n(rst_n), .d(strap_in), .q(strap_sync));

    fsel_seq #(.HANDOFF_CYC(HANDOFF_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .strap_sync(strap_sync),
        .run(run), .pin_oe(pin_oe), .strap_lat(fs_default));

    fsel_decode u_dec (
        .run(run), .strap_lat(fs_default), .src_sel(src_sel), .ss_en(ss_en),
        .reg_fs(reg_fs), .src_ss_en(src_ss_en), .fs_code(fs_code),
        .hiz_req(hiz_req), .cpu_ss_on(cpu_ss_on), .src_ss_on(src_ss_on));

    AST_OE_AFTER_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_oe[0]) |-> $stable(fs_default)) else $error("oe");        // R3
    AST_SS_NEEDS_FS4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ss_on |-> fs_code[FS_W-1]) else $error("fs4");                  // R7
    AST_PARKED_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe == '0) |-> (fs_code == '0 && hiz_req)) else $error("park"); // R1
endmodule

// File: tb/fsel_strap_ctrl_tb.sv
module fsel_strap_ctrl_tb;
    localparam int NS = 3;
    localparam int HC = 2;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       por_n = 0;
    logic [2:0] strap_in = 0;
    logic       src_sel = 0, ss_en = 0, src_ss_en = 0;
    logic [4:0] reg_fs = 0;
    logic [2:0] pin_oe, fs_default;
    logic [4:0] fs_code;
    logic       hiz_req, cpu_ss_on, src_ss_on;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fsel_strap_ctrl #(.SYNC_STAGES(NS), .HANDOFF_CYC(HC)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .strap_in(strap_in),
        .src_sel(src_sel), .ss_en(ss_en), .reg_fs(reg_fs), .src_ss_en(src_ss_en),
        .pin_oe(pin_oe), .fs_default(fs_default), .fs_code(fs_code),
        .hiz_req(hiz_req), .cpu_ss_on(cpu_ss_on), .src_ss_on(src_ss_on));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [4:0] exp_code(input logic [2:0] lat);
        return src_sel ? reg_fs : {reg_fs[4:3], lat};
    endfunction

    task automatic check_run(input logic [2:0] lat);
        logic [4:0] c;
        #1;
        c = exp_code(lat);
        chk("R5", fs_code, c);
        chk("R6", hiz_req, c == 0);
        chk("R7", cpu_ss_on, ss_en & c[4]);
        chk("R8", src_ss_on, ss_en & c[4] & src_ss_en);
    endtask

    task automatic power_up(input logic [2:0] s);
        strap_in = s;
        edges(NS + 2);
        por_n = 1;
        edges(NS + 1);
        chk("R2 capture", fs_default, s);
        chk("R3 oe off in hand-off", pin_oe, 3'b000);
        edges(HC - 1);
        chk("R3 oe still off", pin_oe, 3'b000);
        edges(1);
        chk("R3 oe on", pin_oe, 3'b111);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        rst_n = 1;
        reg_fs = 5'b10101; ss_en = 1; src_ss_en = 1; src_sel = 1;
        edges(2);
        chk("R1 oe", pin_oe, 3'b000);
        chk("R1 code", fs_code, 5'd0);
        chk("R1 hiz", hiz_req, 1'b1);
        chk("R1 ss", {cpu_ss_on, src_ss_on}, 2'b00);

        power_up(3'b101);
        // R4: straps move after capture, frozen value must not
        strap_in = 3'b010; src_sel = 0;
        edges(NS + 3);
        chk("R4 default", fs_default, 3'b101);
        check_run(3'b101);

        // directed: zero code, spread combinations
        src_sel = 1; reg_fs = 5'b00000; ss_en = 1; src_ss_en = 1; check_run(3'b101);
        reg_fs = 5'b10000; ss_en = 1; src_ss_en = 0; check_run(3'b101);
        reg_fs = 5'b10000; ss_en = 0; src_ss_en = 1; check_run(3'b101);
        reg_fs = 5'b01111; ss_en = 1; src_ss_en = 1; check_run(3'b101);
        src_sel = 0; reg_fs = 5'b11000; check_run(3'b101);

        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            src_sel = $urandom; ss_en = $urandom; src_ss_en = $urandom;
            reg_fs = $urandom; strap_in = $urandom;
            check_run(3'b101);
        end

        // R9: power-on reset again with new straps
        por_n = 0;
        edges(NS + 1);
        chk("R9 oe off", pin_oe, 3'b000);
        chk("R9 hiz", hiz_req, 1'b1);
        power_up(3'b000);
        src_sel = 0; reg_fs = 5'b00111; check_run(3'b000);
        reg_fs = 5'b10111; ss_en = 1; src_ss_en = 1; check_run(3'b000);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            src_sel = $urandom; ss_en = $urandom; src_ss_en = $urandom;
            reg_fs = $urandom; strap_in = $urandom;
            check_run(3'b000);
        end
        chk("R4 default after run", fs_default, 3'b000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule